// File: doc/BRIEF.md
# S/PDIF Consumer Channel-Status Serializer

This block produces the channel-status bit stream that an S/PDIF transmitter inserts into its subframes in consumer mode. The transmitter's framing logic strobes the block once per subframe, says whether the subframe is the first or second of its frame, and marks the start of a status block. For every strobe the block returns one status bit on the following clock, together with the frame index it belongs to. It also raises a one-cycle pulse when the last subframe of a block has been served.

The status word is assembled from plain configuration inputs: consumer/professional flag, non-PCM flag, copy permission, emphasis, category, source number, two per-subframe channel numbers, sample-frequency code, clock accuracy and word-length fields. Only the first 40 frame positions of the 192-frame block carry content; the rest are sent as zero. The configuration is captured when a block begins, so a block never mixes old and new field values. Line coding, preambles and parity are handled elsewhere in the transmitter.

Top module: `spdif_cstat_serializer`

## Requirements
- R1: After reset, cs_valid, cs_bit, cs_sub, blk_done are 0 and cs_idx is 0.
- R2: Each cycle with sf_stb high yields exactly one cycle of cs_valid high on the next clock, with cs_sub equal to the sf_is_b value of that strobe; no cs_valid appears without a strobe.
- R3: A strobe of the first subframe (sf_is_b=0) with blk_start=1 restarts the block at frame index 0; blk_start given with a second-subframe strobe (sf_is_b=1) has no effect on the index or the captured configuration.
- R4: Both subframes of a frame report the same cs_idx; the index advances by one after each second-subframe strobe and returns from FRAMES-1 (191) to 0.
- R5: Frame indices 40 to 191 always carry cs_bit = 0.
- R6: Frame index n carries status bit n, each field sent LSB first at its lowest index: 0 professional flag, 1 non-PCM flag, 2 copy flag, 5:3 emphasis, 7:6 zero, 15:8 category, 19:16 source number, 27:24 sample-frequency code, 29:28 clock accuracy, 31:30 zero, 32 maximum-length select, 35:33 word length, 39:36 zero.
- R7: Indices 21:20 carry the first-subframe channel number in first subframes and zero in second subframes; indices 23:22 carry the second-subframe channel number in second subframes and zero in first subframes; every other index is equal in both subframes.
- R8: The configuration is captured at the first-subframe strobe that begins a block (index 0, by blk_start or by wrap); that strobe already uses the inputs present with it, and later input changes have no effect until the next block begins.
- R9: blk_done pulses for one cycle together with the output of the second subframe of frame 191, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_stb | input | 1 | One-cycle request for the status bit of a subframe |
| sf_is_b | input | 1 | 0 = first subframe of the frame, 1 = second |
| blk_start | input | 1 | Block begins at this strobe (honoured on first subframes only) |
| cfg_pro | input | 1 | Professional-use flag (0 = consumer) |
| cfg_nonpcm | input | 1 | Non-PCM content flag (0 = linear PCM) |
| cfg_copy | input | 1 | Copy permission flag |
| cfg_emph | input | 3 | Emphasis code |
| cfg_cat | input | 8 | Category code |
| cfg_src | input | 4 | Source number |
| cfg_chan_a | input | 2 | Channel number for first subframes |
| cfg_chan_b | input | 2 | Channel number for second subframes |
| cfg_fs | input | 4 | Sample-frequency code |
| cfg_clkacc | input | 2 | Clock accuracy (00 level II, 01 level I, 10 level III) |
| cfg_maxwl | input | 1 | Maximum sample length select (0 = 20 bits, 1 = 24 bits) |
| cfg_wl | input | 3 | Word-length code (000 = not indicated) |
| cs_valid | output | 1 | Registered: a status bit is presented |
| cs_bit | output | 1 | Registered status bit |
| cs_sub | output | 1 | Subframe the bit belongs to |
| cs_idx | output | IDX_W | Frame index of the bit within the block |
| blk_done | output | 1 | Pulse with the final bit of a block |

## Verification
The bench predicts every output from a field-by-field model and attacks the places where an off-by-one or a misplaced capture would show. It changes the configuration in the middle of a block, where a design that reads the inputs live would send a block of mixed fields, and changes it again right before a wrap, where a design capturing one strobe late would send frame 0 from the old values. It issues blk_start on a second subframe, which a design that obeys it would use to restart mid-frame, and a real restart in mid-block, after which a counter that does not reload would report a stale index. Wrap and blk_done are watched across several blocks, where a counter that wraps at 192 instead of after 191, or advances on the wrong subframe, would split a frame across two indices or mistime the pulse.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;

  // Number of frame positions that carry content in consumer mode.
  localparam int CS_USED = 40;

  typedef struct packed {
    logic       pro;
    logic       nonpcm;
    logic       copy;
    logic [2:0] emph;
    logic [7:0] cat;
    logic [3:0] src;
    logic [1:0] chan_a;
    logic [1:0] chan_b;
    logic [3:0] fs;
    logic [1:0] clkacc;
    logic       maxwl;
    logic [2:0] wl;
  } cs_cfg_t;

  // Assemble the content part of the status block for one subframe.
  function automatic logic [CS_USED-1:0] cs_word(input cs_cfg_t c, input logic second);
    logic [CS_USED-1:0] w;
    w        = '0;
    w[0]     = c.pro;
    w[1]     = c.nonpcm;
    w[2]     = c.copy;
    w[5:3]   = c.emph;
    w[15:8]  = c.cat;
    w[19:16] = c.src;
    w[21:20] = second ? 2'b00 : c.chan_a;
    w[23:22] = second ? c.chan_b : 2'b00;
    w[27:24] = c.fs;
    w[29:28] = c.clkacc;
    w[32]    = c.maxwl;
    w[35:33] = c.wl;
    return w;
  endfunction

endpackage

// File: rtl/cs_frame_ctr.sv
module cs_frame_ctr #(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_stb,
  input  logic             sf_is_b,
  input  logic             blk_start,
  output logic [IDX_W-1:0] cur_idx,
  output logic             open_blk,
  output logic             last_frm
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [IDX_W-1:0] frm_q;
  logic             restart;

  // Restart only on a first-subframe strobe.
  assign restart  = sf_stb & ~sf_is_b & blk_start;
  assign cur_idx  = restart ? '0 : frm_q;
  assign open_blk = sf_stb & ~sf_is_b & (blk_start | (frm_q == '0));
  assign last_frm = (cur_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q <= '0;
    end else if (sf_stb) begin
      if (!sf_is_b) frm_q <= cur_idx;
      else          frm_q <= (frm_q == LAST) ? '0 : frm_q + 1'b1;
    end
  end

endmodule

// File: rtl/cs_cfg_hold.sv
module cs_cfg_hold
  import spdif_cs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load,
  input  cs_cfg_t cfg_in,
  output cs_cfg_t cfg_eff
);
  cs_cfg_t cfg_q;

  // The opening strobe already uses the live inputs.
  assign cfg_eff = load ? cfg_in : cfg_q;

  always_ff @(posedge clk) begin
    if (rst)       cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end

endmodule

// File: rtl/cs_bit_pick.sv
module cs_bit_pick
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  cs_cfg_t          cfg,
  input  logic [IDX_W-1:0] idx,
  input  logic             second,
  output logic             bit_o
);
  logic [CS_USED-1:0] word [2];
  logic [CS_USED-1:0] sel;
  logic [CS_USED-1:0] shifted;

  for (genvar s = 0; s < 2; s++) begin : g_sub
    assign word[s] = cs_word(cfg, s[0]);
  end

  assign sel     = second ? word[1] : word[0];
  assign shifted = sel >> idx;
  assign bit_o   = (idx < IDX_W'(CS_USED)) ? shifted[0] : 1'b0;

endmodule

// File: rtl/spdif_cstat_serializer.sv
module spdif_cstat_serializer
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sf_stb,
  input  logic             sf_is_b,
  input  logic             blk_start,
  input  logic             cfg_pro,
  input  logic             cfg_nonpcm,
  input  logic             cfg_copy,
  input  logic [2:0]       cfg_emph,
  input  logic [7:0]       cfg_cat,
  input  logic [3:0]       cfg_src,
  input  logic [1:0]       cfg_chan_a,
  input  logic [1:0]       cfg_chan_b,
  input  logic [3:0]       cfg_fs,
  input  logic [1:0]       cfg_clkacc,
  input  logic             cfg_maxwl,
  input  logic [2:0]       cfg_wl,
  output logic             cs_valid,
  output logic             cs_bit,
  output logic             cs_sub,
  output logic [IDX_W-1:0] cs_idx,
  output logic             blk_done
);
  cs_cfg_t          cfg_live;
  cs_cfg_t          cfg_eff;
  logic [IDX_W-1:0] cur_idx;
  logic             open_blk;
  logic             last_frm;
  logic             pick;

  assign cfg_live.pro    = cfg_pro;
  assign cfg_live.nonpcm = cfg_nonpcm;
  assign cfg_live.copy   = cfg_copy;
  assign cfg_live.emph   = cfg_emph;
  assign cfg_live.cat    = cfg_cat;
  assign cfg_live.src    = cfg_src;
  assign cfg_live.chan_a = cfg_chan_a;
  assign cfg_live.chan_b = cfg_chan_b;
  assign cfg_live.fs     = cfg_fs;
  assign cfg_live.clkacc = cfg_clkacc;
  assign cfg_live.maxwl  = cfg_maxwl;
  assign cfg_live.wl     = cfg_wl;

  cs_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .sf_stb    (sf_stb),
    .sf_is_b   (sf_is_b),
    .blk_start (blk_start),
    .cur_idx   (cur_idx),
    .open_blk  (open_blk),
    .last_frm  (last_frm)
  );

  cs_cfg_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (open_blk),
    .cfg_in  (cfg_live),
    .cfg_eff (cfg_eff)
  );

  cs_bit_pick #(.FRAMES(FRAMES)) u_pick (
    .cfg    (cfg_eff),
    .idx    (cur_idx),
    .second (sf_is_b),
    .bit_o  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_valid <= 1'b0;
      cs_bit   <= 1'b0;
      cs_sub   <= 1'b0;
      cs_idx   <= '0;
      blk_done <= 1'b0;
    end else begin
      cs_valid <= sf_stb;
      blk_done <= sf_stb & sf_is_b & last_frm;
      if (sf_stb) begin
        cs_bit <= pick;
        cs_sub <= sf_is_b;
        cs_idx <= cur_idx;
      end
    end
  end

endmodule

// File: rtl/cs_serializer_chk.sv
module cs_serializer_chk
  import spdif_cs_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst,
  input logic             sf_stb,
  input logic             sf_is_b,
  input logic             blk_start,
  input logic             cs_valid,
  input logic             cs_bit,
  input logic             cs_sub,
  input logic [IDX_W-1:0] cs_idx,
  input logic             blk_done
);
  p_valid_after_stb_r2: assert property (@(posedge clk) disable iff (rst)
    sf_stb |=> cs_valid);

  p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !sf_stb |=> !cs_valid);

  p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (sf_stb && !sf_is_b && blk_start) |=> (cs_idx == '0));

  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cs_valid |-> (cs_idx <= IDX_W'(FRAMES - 1)));

  p_tail_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (cs_valid && (cs_idx >= IDX_W'(CS_USED))) |-> !cs_bit);

  p_done_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> (cs_valid && cs_sub && (cs_idx == IDX_W'(FRAMES - 1))));

endmodule

bind spdif_cstat_serializer cs_serializer_chk #(.FRAMES(FRAMES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sf_stb    (sf_stb),
  .sf_is_b   (sf_is_b),
  .blk_start (blk_start),
  .cs_valid  (cs_valid),
  .cs_bit    (cs_bit),
  .cs_sub    (cs_sub),
  .cs_idx    (cs_idx),
  .blk_done  (blk_done)
);

// File: tb/spdif_cstat_serializer_bench.sv
`timescale 1ns/1ps
module spdif_cstat_serializer_bench;
  localparam int FRAMES = 192;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic       pro;
    logic       nonpcm;
    logic       copy;
    logic [2:0] emph;
    logic [7:0] cat;
    logic [3:0] src;
    logic [1:0] cha;
    logic [1:0] chb;
    logic [3:0] fs;
    logic [1:0] clk_acc;
    logic       maxwl;
    logic [2:0] wl;
  } bcfg_t;

  typedef struct packed {
    logic [7:0] idx;
    logic       sub;
    logic       bitv;
    logic       done;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic sf_stb = 1'b0, sf_is_b = 1'b0, blk_start = 1'b0;
  bcfg_t live = '0, snap = '0;
  logic cs_valid, cs_bit, cs_sub, blk_done;
  logic [IDX_W-1:0] cs_idx;

  exp_t  q[$];
  int    n_chk = 0, n_bad = 0;
  int    mfrm = 0;
  string tag = "R6";

  spdif_cstat_serializer #(.FRAMES(FRAMES)) u_spdif_cstat_serializer (
    .clk(clk), .rst(rst), .sf_stb(sf_stb), .sf_is_b(sf_is_b), .blk_start(blk_start),
    .cfg_pro(live.pro), .cfg_nonpcm(live.nonpcm), .cfg_copy(live.copy),
    .cfg_emph(live.emph), .cfg_cat(live.cat), .cfg_src(live.src),
    .cfg_chan_a(live.cha), .cfg_chan_b(live.chb), .cfg_fs(live.fs),
    .cfg_clkacc(live.clk_acc), .cfg_maxwl(live.maxwl), .cfg_wl(live.wl),
    .cs_valid(cs_valid), .cs_bit(cs_bit), .cs_sub(cs_sub), .cs_idx(cs_idx),
    .blk_done(blk_done)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // Expected status bit from the field layout of R6/R7.
  function automatic logic exp_bit(input int i, input logic sub);
    bcfg_t c = snap;
    if (i == 0) return c.pro;
    if (i == 1) return c.nonpcm;
    if (i == 2) return c.copy;
    if (i >= 3 && i <= 5) return c.emph[i-3];
    if (i >= 8 && i <= 15) return c.cat[i-8];
    if (i >= 16 && i <= 19) return c.src[i-16];
    if (i >= 20 && i <= 21) return sub ? 1'b0 : c.cha[i-20];
    if (i >= 22 && i <= 23) return sub ? c.chb[i-22] : 1'b0;
    if (i >= 24 && i <= 27) return c.fs[i-24];
    if (i >= 28 && i <= 29) return c.clk_acc[i-28];
    if (i == 32) return c.maxwl;
    if (i >= 33 && i <= 35) return c.wl[i-33];
    return 1'b0;
  endfunction

  // Driver: entered at a falling edge, leaves at a falling edge.
  task automatic send(input logic sub, input logic bs, input int gap);
    exp_t e;
    if (!sub && (bs || mfrm == 0)) begin
      mfrm = 0;
      snap = live;
    end
    e.idx  = 8'(mfrm);
    e.sub  = sub;
    e.bitv = exp_bit(mfrm, sub);
    e.done = sub && (mfrm == FRAMES - 1);
    if (sub) mfrm = (mfrm == FRAMES - 1) ? 0 : mfrm + 1;
    q.push_back(e);
    sf_stb = 1'b1; sf_is_b = sub; blk_start = bs;
    @(negedge clk);
    sf_stb = 1'b0; blk_start = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frames(input int n, input logic first_bs, input int gap_mod);
    for (int f = 0; f < n; f++) begin
      send(1'b0, first_bs && f == 0, 0);
      send(1'b1, 1'b0, (gap_mod != 0 && f % gap_mod == 0) ? 2 : 0);
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && cs_valid) begin
      if (q.size() == 0) begin
        chk("R2 output without strobe", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string bt;
        e = q.pop_front();
        if (e.idx >= 40) bt = "R5 tail bit";
        else if (e.idx >= 20 && e.idx <= 23) bt = "R7 channel bit";
        else bt = {tag, " status bit"};
        chk("R4 index", 32'(cs_idx), 32'(e.idx));
        chk("R2 subframe", 32'(cs_sub), 32'(e.sub));
        chk(bt, 32'(cs_bit), 32'(e.bitv));
        chk("R9 block done", 32'(blk_done), 32'(e.done));
      end
    end else if (!rst) begin
      chk("R9 done without output", 32'(blk_done), 32'd0);
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(cs_valid), 32'd0);
    chk("R1 bit",   32'(cs_bit),   32'd0);
    chk("R1 sub",   32'(cs_sub),   32'd0);
    chk("R1 idx",   32'(cs_idx),   32'd0);
    chk("R1 done",  32'(blk_done), 32'd0);

    // R6 / R7: one full block with a mixed configuration.
    live = '{pro:1'b0, nonpcm:1'b1, copy:1'b1, emph:3'b100, cat:8'hA5, src:4'h9,
             cha:2'b01, chb:2'b10, fs:4'h2, clk_acc:2'b01, maxwl:1'b1, wl:3'b101};
    tag = "R6";
    frames(FRAMES, 1'b1, 7);

    // R8: change inputs mid-block, block wraps by itself.
    tag = "R8";
    frames(100, 1'b0, 0);
    live = '{pro:1'b1, nonpcm:1'b0, copy:1'b0, emph:3'b011, cat:8'h3C, src:4'h6,
             cha:2'b10, chb:2'b01, fs:4'hD, clk_acc:2'b10, maxwl:1'b0, wl:3'b010};
    frames(FRAMES - 100, 1'b0, 5);
    frames(60, 1'b0, 0);
    live = '1;
    frames(FRAMES - 60, 1'b0, 0);
    frames(FRAMES, 1'b0, 3);

    // R3: blk_start on a second subframe is ignored, on a first one restarts.
    tag = "R3";
    frames(50, 1'b0, 0);
    live = '{pro:1'b0, nonpcm:1'b0, copy:1'b1, emph:3'b001, cat:8'h81, src:4'h3,
             cha:2'b11, chb:2'b11, fs:4'h8, clk_acc:2'b00, maxwl:1'b1, wl:3'b011};
    send(1'b0, 1'b0, 0);
    send(1'b1, 1'b1, 1);
    send(1'b0, 1'b1, 0);
    send(1'b1, 1'b0, 0);
    frames(FRAMES + 10, 1'b0, 11);

    repeat (3) @(negedge clk);
    chk("R2 pending outputs", 32'(q.size()), 32'd0);
    finish_run();
  end

endmodule